// File: doc/BRIEF.md
# Sixty-Four State Viterbi Decoder

This block decodes a rate 1/2 convolutional code with constraint length 7, which gives a 64-state trellis. An upstream unit supplies, on every cycle that `in_valid` is high, four branch metrics: one cost for each of the four coded pairs the encoder could have sent. The decoder runs add-compare-select across all 64 states, writes one 64-bit survivor decision word per symbol into an internal circular store, and runs traceback to recover one hard data bit per input symbol. Decoded bits leave in symbol order, one per cycle at most, each marked by `out_valid`.

Two operating modes are chosen by `blk_mode`. In continuous mode, traceback begins at the state with the lowest path metric and runs over a settling depth of `TB_LEN` symbols (170 by default). The newest `TB_LEN` or more symbols are always held back. In block mode, each block is framed by start and stop markers and ends with six zero tail bits. Every block start resets the path metrics so that state 0 is favoured. Traceback for a finished block begins in state 0 at the stop symbol, and every symbol of the block is flushed out, tail included. The markers travel with the data, so they come out aligned with the first and last decoded bit of each block.

Top module: `vit64_decoder`

## Requirements
- R1: While reset is active and until decoded bits are available after reset, `out_valid` stays low.
- R2: The encoder convention is as follows. The register is `{u, s5..s0}`, with the newest bit `u` in the MSB. The coded pair is `c0 = parity(reg & 171 octal)` and `c1 = parity(reg & 133 octal)`. The branch metric for pair `{c0,c1}` sits in slot `2*c0+c1` of `in_bm`, at bits `[slot*BM_W +: BM_W]`, and a lower value means more likely. With error-free metrics, the decoded bits equal the encoded data bits, in order.
- R3: Single coded-bit errors spaced at least 25 symbols apart are corrected, in both modes.
- R4: In continuous mode, after N ≥ `TB_LEN+CHUNK` symbols and an idle drain, the number of bits still not output lies between `TB_LEN` and `TB_LEN+CHUNK-1` inclusive.
- R5: In block mode, every symbol from start marker to stop marker is output exactly once, including the six zero tail symbols. Traceback of a finished block begins in state 0.
- R6: `out_blk_start` is high on exactly the first decoded bit of a block, and `out_blk_stop` is high on exactly the last.
- R7: Blocks sent back to back, with the next block's start symbol in the cycle right after the previous block's stop symbol, decode correctly. Each block start resets the path metrics.
- R8: Metric values and markers presented while `in_valid` is low have no effect on the output stream.
- R9: Path metrics are renormalised by subtracting the minimum whenever any metric has its MSB set. Adding one common offset to all four branch metrics, up to the `BM_W` limit, leaves the output unchanged over runs much longer than the metric range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol present this cycle |
| in_bm | input | 4*BM_W | Four branch metrics, slot `2*c0+c1` |
| in_blk_start | input | 1 | Symbol is the first of a block |
| in_blk_stop | input | 1 | Symbol is the last of a block |
| blk_mode | input | 1 | 1 = block mode, 0 = continuous; held static between resets |
| out_valid | output | 1 | Decoded bit present |
| out_bit | output | 1 | Decoded data bit |
| out_blk_start | output | 1 | First decoded bit of a block |
| out_blk_stop | output | 1 | Last decoded bit of a block |

## Verification
In block mode, a flush of a finished block can run while the first symbols of the next block are already arriving. In that case, path metric reset, survivor writes and traceback reads all hit the decision store together. The bench provokes this by sending blocks back to back with no idle cycle, mixing block lengths and adding sparse errors. A boundary that is mishandled shows up as wrong bits or misplaced markers when the captured stream is compared with the transmitted data. In a second coincidence, renormalisation falls in the same cycle as ordinary metric updates and traceback starts. A long run with a large common branch-metric offset forces this repeatedly, with idle cycles carrying garbage values in between.

// File: rtl/vit64_pkg.sv
package vit64_pkg;
    localparam int K_LEN  = 7;
    localparam int S_BITS = K_LEN - 1;
    localparam int N_ST   = 1 << S_BITS;
    localparam logic [K_LEN-1:0] GEN_A = 7'o171;
    localparam logic [K_LEN-1:0] GEN_B = 7'o133;

    // coded pair {c0,c1} for register {newest bit, state}
    function automatic logic [1:0] pair_code(input logic [K_LEN-1:0] reg_v);
        return {^(reg_v & GEN_A), ^(reg_v & GEN_B)};
    endfunction
endpackage

// File: rtl/vit64_acs.sv
module vit64_acs
    import vit64_pkg::*;
#(
    parameter int BM_W = 4,
    parameter int PM_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4*BM_W-1:0] in_bm,
    input  logic              reinit,
    output logic [N_ST-1:0]   dec_o,
    output logic [S_BITS-1:0] best_o
);
    localparam logic [PM_W-1:0] INIT_PM = PM_W'(1) << (PM_W - 3);

    typedef struct packed {
        logic [N_ST-1:0][PM_W-1:0] pm;
    } acs_t;

    function automatic acs_t reset_val();
        acs_t r;
        for (int s = 0; s < N_ST; s++) r.pm[s] = (s == 0) ? '0 : INIT_PM;
        return r;
    endfunction

    acs_t q, d;
    logic [PM_W-1:0]   pm_min;
    logic [S_BITS-1:0] pm_arg;
    logic              need_norm;

    always_comb begin
        pm_min    = q.pm[0];
        pm_arg    = '0;
        need_norm = 1'b0;
        for (int s = 0; s < N_ST; s++) begin
            if (q.pm[s] < pm_min) begin
                pm_min = q.pm[s];
                pm_arg = S_BITS'(s);
            end
            need_norm = need_norm | q.pm[s][PM_W-1];
        end
    end

    assign best_o = pm_arg;

    always_comb begin
        logic [PM_W-1:0]   base [N_ST];
        logic [PM_W-1:0]   sub;
        logic [S_BITS-1:0] sv, p0, p1;
        logic [1:0]        c0, c1;
        logic [PM_W:0]     m0, m1;
        d     = q;
        dec_o = '0;
        sub   = (reinit || !need_norm) ? '0 : pm_min;
        for (int s = 0; s < N_ST; s++)
            base[s] = reinit ? ((s == 0) ? '0 : INIT_PM) : q.pm[s];
        for (int s = 0; s < N_ST; s++) begin
            sv = S_BITS'(s);
            p0 = {sv[S_BITS-2:0], 1'b0};
            p1 = {sv[S_BITS-2:0], 1'b1};
            c0 = pair_code({sv[S_BITS-1], p0});
            c1 = pair_code({sv[S_BITS-1], p1});
            m0 = {1'b0, base[p0]} + (PM_W+1)'(in_bm[c0*BM_W +: BM_W]);
            m1 = {1'b0, base[p1]} + (PM_W+1)'(in_bm[c1*BM_W +: BM_W]);
            dec_o[s] = (m1 < m0);
            if (in_valid)
                d.pm[s] = PM_W'(((m1 < m0) ? m1 : m0) - {1'b0, sub});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_val();
        else        q <= d;
    end

    logic [PM_W-1:0] pm_max;
    always_comb begin
        pm_max = q.pm[0];
        for (int s = 0; s < N_ST; s++)
            if (q.pm[s] > pm_max) pm_max = q.pm[s];
    end

    // R9
    pm_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_max - pm_min) < (PM_W'(1) << (PM_W - 1)));

    // R8
    pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q.pm));
endmodule

// File: rtl/vit64_trace.sv
module vit64_trace
    import vit64_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int TB_LEN = 170,
    parameter int CHUNK  = 32,
    parameter int STEPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [N_ST-1:0]   wr_dec,
    input  logic              wr_start,
    input  logic              wr_stop,
    input  logic              blk_mode,
    input  logic [S_BITS-1:0] best_i,
    output logic              out_valid,
    output logic              out_bit,
    output logic              out_start,
    output logic              out_stop
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     head;
        logic [AW-1:0]     dptr;
        logic [AW-1:0]     optr;
        logic [AW-1:0]     tb_idx;
        logic [AW-1:0]     tb_end;
        logic [AW-1:0]     tb_left;
        logic [AW-1:0]     tb_skip;
        logic [AW-1:0]     stop_idx;
        logic [S_BITS-1:0] tb_st;
        logic              busy;
        logic              stop_pend;
        logic              ov;
        logic              ob;
        logic              os;
        logic              oe;
    } tr_t;

    tr_t q, d;

    logic [N_ST-1:0] dec_mem  [DEPTH];
    logic [1:0]      mark_mem [DEPTH];   // {stop, start}
    logic            bit_mem  [DEPTH];

    logic [STEPS-1:0] bw_en;
    logic [AW-1:0]    bw_idx [STEPS];
    logic             bw_val [STEPS];

    always_comb begin
        logic [AW-1:0]     pend, idx, left, skip;
        logic [S_BITS-1:0] st;
        logic              go_flush, go_cont;
        d     = q;
        bw_en = '0;
        for (int k = 0; k < STEPS; k++) begin
            bw_idx[k] = '0;
            bw_val[k] = 1'b0;
        end
        pend = q.head - q.dptr;
        idx  = q.tb_idx;
        st   = q.tb_st;
        left = q.tb_left;
        skip = q.tb_skip;
        go_flush = !q.busy && q.stop_pend;
        go_cont  = !q.busy && !q.stop_pend && !blk_mode
                   && (pend >= AW'(TB_LEN + CHUNK));
        if (go_flush) begin
            d.busy      = 1'b1;
            d.tb_idx    = q.stop_idx;
            d.tb_st     = '0;
            d.tb_left   = q.stop_idx - q.dptr + 1'b1;
            d.tb_skip   = '0;
            d.tb_end    = q.stop_idx + 1'b1;
            d.stop_pend = 1'b0;
        end else if (go_cont) begin
            d.busy    = 1'b1;
            d.tb_idx  = q.head - 1'b1;
            d.tb_st   = best_i;
            d.tb_left = pend;
            d.tb_skip = AW'(TB_LEN);
            d.tb_end  = q.head - AW'(TB_LEN);
        end else if (q.busy) begin
            for (int k = 0; k < STEPS; k++) begin
                if (left != '0) begin
                    if (skip == '0) begin
                        bw_en[k]  = 1'b1;
                        bw_idx[k] = idx;
                        bw_val[k] = st[S_BITS-1];
                    end else begin
                        skip = skip - 1'b1;
                    end
                    if (blk_mode && mark_mem[idx][0]) st = '0;
                    else st = {st[S_BITS-2:0], dec_mem[idx][st]};
                    idx  = idx - 1'b1;
                    left = left - 1'b1;
                end
            end
            d.tb_idx  = idx;
            d.tb_st   = st;
            d.tb_left = left;
            d.tb_skip = skip;
            if (left == '0) begin
                d.busy = 1'b0;
                d.dptr = q.tb_end;
            end
        end
        if (wr_en) begin
            d.head = q.head + 1'b1;
            if (wr_stop && blk_mode) begin
                d.stop_pend = 1'b1;
                d.stop_idx  = q.head;
            end
        end
        if (q.optr != q.dptr) begin
            d.ov           = 1'b1;
            d.ob           = bit_mem[q.optr];
            {d.oe, d.os}   = mark_mem[q.optr];
            d.optr         = q.optr + 1'b1;
        end else begin
            d.ov = 1'b0;
            d.ob = 1'b0;
            d.os = 1'b0;
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dec_mem[q.head]  <= wr_dec;
            mark_mem[q.head] <= {wr_stop, wr_start};
        end
        for (int k = 0; k < STEPS; k++)
            if (bw_en[k]) bit_mem[bw_idx[k]] <= bw_val[k];
    end

    assign out_valid = q.ov;
    assign out_bit   = q.ob;
    assign out_start = q.os;
    assign out_stop  = q.oe;

    // R5
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && q.stop_pend) |=> (q.busy && q.tb_st == '0));

    // R2
    out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.optr != q.dptr) |=> (q.ov && q.optr == AW'($past(q.optr) + 1'b1)));

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (q.head == $past(q.head)));

    // R4
    room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(q.head - q.optr) != AW'(DEPTH - 1));
endmodule

// File: rtl/vit64_decoder.sv
module vit64_decoder
    import vit64_pkg::*;
#(
    parameter int BM_W   = 4,
    parameter int PM_W   = 10,
    parameter int TB_LEN = 170,
    parameter int CHUNK  = 32,
    parameter int DEPTH  = 1024,
    parameter int STEPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4*BM_W-1:0] in_bm,
    input  logic              in_blk_start,
    input  logic              in_blk_stop,
    input  logic              blk_mode,
    output logic              out_valid,
    output logic              out_bit,
    output logic              out_blk_start,
    output logic              out_blk_stop
);
    logic [N_ST-1:0]   dec_w;
    logic [S_BITS-1:0] best_w;
    logic              reinit_w;

    assign reinit_w = in_valid && in_blk_start && blk_mode;

    vit64_acs #(.BM_W(BM_W), .PM_W(PM_W)) u_acs (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bm    (in_bm),
        .reinit   (reinit_w),
        .dec_o    (dec_w),
        .best_o   (best_w)
    );

    vit64_trace #(.DEPTH(DEPTH), .TB_LEN(TB_LEN), .CHUNK(CHUNK), .STEPS(STEPS)) u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_dec    (dec_w),
        .wr_start  (in_blk_start),
        .wr_stop   (in_blk_stop),
        .blk_mode  (blk_mode),
        .best_i    (best_w),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_start (out_blk_start),
        .out_stop  (out_blk_stop)
    );
endmodule

// File: tb/test_vit64_decoder.sv
`timescale 1ns/1ps
module test_vit64_decoder;
    localparam int BMW  = 4;
    localparam int TBL  = 40;
    localparam int CHK  = 16;
    localparam int MAXN = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [4*BMW-1:0] in_bm = '0;
    logic in_blk_start = 1'b0, in_blk_stop = 1'b0, blk_mode = 1'b0;
    logic out_valid, out_bit, out_blk_start, out_blk_stop;

    always #2.5 clk = ~clk;

    vit64_decoder #(.BM_W(BMW), .PM_W(10), .TB_LEN(TBL), .CHUNK(CHK),
                    .DEPTH(256), .STEPS(2)) i_vit64_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bm(in_bm),
        .in_blk_start(in_blk_start), .in_blk_stop(in_blk_stop), .blk_mode(blk_mode),
        .out_valid(out_valid), .out_bit(out_bit),
        .out_blk_start(out_blk_start), .out_blk_stop(out_blk_stop));

    bit exp_b [MAXN]; bit exp_s [MAXN]; bit exp_e [MAXN];
    bit got_b [MAXN]; bit got_s [MAXN]; bit got_e [MAXN];
    int exp_n = 0, got_n = 0, total = 0, bad = 0;
    logic [5:0] enc = '0;

    always @(negedge clk) begin
        if (!rst_n) got_n = 0;
        else if (out_valid) begin
            if (got_n < MAXN) begin
                got_b[got_n] = out_bit; got_s[got_n] = out_blk_start; got_e[got_n] = out_blk_stop;
            end
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input bit mode);
        int seen = 0;
        rst_n = 1'b0; in_valid = 1'b0; blk_mode = mode;
        repeat (3) @(negedge clk);
        seen += out_valid;
        rst_n = 1'b1; enc = '0; exp_n = 0;
        repeat (5) begin @(negedge clk); seen += out_valid; end
        chk(seen == 0, "R1", "out_valid high around reset", seen, 0);
    endtask

    task automatic send(input bit u, input bit f0, input bit f1, input int off, input bit st, input bit sp);
        logic [6:0] r; bit c0, c1, y0, y1; int dd;
        r = {u, enc}; c0 = ^(r & 7'o171); c1 = ^(r & 7'o133);
        y0 = c0 ^ f0; y1 = c1 ^ f1;
        for (int h = 0; h < 4; h++) begin
            dd = int'(y0 != h[1]) + int'(y1 != h[0]);
            in_bm[h*BMW +: BMW] = BMW'(dd*4 + off);
        end
        in_valid = 1'b1; in_blk_start = st; in_blk_stop = sp;
        enc = {u, enc[5:1]};
        if (exp_n < MAXN) begin exp_b[exp_n] = u; exp_s[exp_n] = st; exp_e[exp_n] = sp; end
        exp_n++;
        @(negedge clk);
        in_valid = 1'b0; in_blk_start = 1'b0; in_blk_stop = 1'b0;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_bm = BMW'($urandom) == 0 ? '1 : 16'($urandom);
            in_blk_start = 1'($urandom); in_blk_stop = 1'($urandom);
            @(negedge clk);
        end
        in_blk_start = 1'b0; in_blk_stop = 1'b0;
    endtask

    task automatic cmp_stream(input string rq_bits, input string rq_mk, input bit blk);
        int mb = -1, mm = -1, diff;
        for (int i = 0; i < got_n && i < MAXN; i++) begin
            if (got_b[i] != exp_b[i] && mb < 0) mb = i;
            if ((got_s[i] != exp_s[i] || got_e[i] != exp_e[i]) && mm < 0) mm = i;
        end
        chk(mb < 0, rq_bits, "first bit mismatch index", mb, -1);
        chk(mm < 0, rq_mk, "first marker mismatch index", mm, -1);
        if (blk) chk(got_n == exp_n, "R5", "block output count", got_n, exp_n);
        else begin
            diff = exp_n - got_n;
            chk(diff >= TBL && diff <= TBL + CHK - 1, "R4", "bits held back", diff, TBL);
        end
    endtask

    task automatic run_cont(input int n, input int pat, input int per, input int off, input int gap_every, input string rq);
        bit u;
        do_reset(1'b0);
        for (int i = 0; i < n; i++) begin
            u = (pat == 0) ? 1'($urandom) : (pat == 2);
            send(u, per > 0 && i % per == per/2 && (i/per) % 2 == 0,
                    per > 0 && i % per == per/2 && (i/per) % 2 == 1, off, 1'b0, 1'b0);
            if (gap_every > 0 && i % gap_every == 3) gap(2);
        end
        gap(400);
        cmp_stream(rq, rq, 1'b0);
    endtask

    task automatic send_block(input int len, input int per);
        bit u;
        enc = '0;
        for (int i = 0; i < len + 6; i++) begin
            u = (i < len) ? 1'($urandom) : 1'b0;
            send(u, per > 0 && i % per == 3, 1'b0, 0, i == 0, i == len + 5);
        end
    endtask

    initial begin
        // R2 clean random stream, R4 hold-back count
        run_cont(500, 0, 0, 0, 0, "R2");
        // R2 constant patterns
        run_cont(300, 1, 0, 0, 0, "R2");
        run_cont(300, 2, 0, 0, 0, "R2");
        // R3 sparse coded-bit errors in continuous mode
        run_cont(600, 0, 25, 0, 0, "R3");
        // R9 large common offset forces renormalisation; R8 garbage on idle cycles
        run_cont(1500, 0, 0, 7, 0, "R9");
        run_cont(400, 0, 0, 0, 7, "R8");
        // R5 R6 block length sweep with garbage idle gaps (R8)
        do_reset(1'b1);
        for (int len = 1; len <= 40; len++) begin send_block(len, 0); gap(3); end
        gap(400);
        cmp_stream("R5", "R6", 1'b1);
        // R7 back-to-back blocks with sparse errors (R3)
        do_reset(1'b1);
        send_block(30, 25); send_block(7, 0); send_block(60, 26);
        send_block(12, 0); send_block(100, 25); send_block(1, 0);
        gap(400);
        cmp_stream("R7", "R6", 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule